// File: doc/BRIEF.md
# Processor to ISA I/O Address Translator

This block connects a processor's memory-mapped I/O aperture to an ISA-style port bus. A processor request whose address falls inside an 8 MB aperture at 0x8000_0000 is sent to the port bus one clock later. The aperture offset is turned into a 16-bit port number in one of two ways:

- **Flat mode:** the low 16 bits of the offset are used directly.
- **Paged mode:** each 4 KB page of the aperture exposes 32 ports. The page number moves down to sit just above the five low offset bits.

A mode input chooses between the two for each request.

The processor is big-endian and the port bus is little-endian, so data lanes are reversed by transfer size:

- Halfwords have their two bytes exchanged.
- Words have all four bytes reversed.
- Bytes pass through unchanged.

Returning read data goes through the same reversal, sized by the read it answers. Each handshake is one cycle wide. Requests outside the aperture, or with the reserved size code, never reach the port bus.

Top module: `iox_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `io_req` and `cpu_rvalid` are 0.
- R2: A request with `cpu_req`=1 and `cpu_addr` in 0x8000_0000..0x807F_FFFF (upper nine bits equal to 0x100) gives `io_req`=1 exactly one cycle later, with `io_we` equal to the request's `cpu_we`. Any other address gives `io_req`=0 in that cycle.
- R3: With `map_sel`=0 (flat), `io_addr` equals `cpu_addr[15:0]`.
- R4: With `map_sel`=1 (paged), `io_addr` equals `{cpu_addr[22:12], cpu_addr[4:0]}`. This is the same as (addr & 0x1F) | ((addr & 0x7FF000) >> 7).
- R5: `map_sel` is sampled in the same cycle as `cpu_req`. A change in any later cycle only affects later requests.
- R6: Size code 0 (byte): `io_wdata` = {24'b0, `cpu_wdata[7:0]`}.
- R7: Size code 1 (halfword): `io_wdata` = {16'b0, `cpu_wdata[7:0]`, `cpu_wdata[15:8]`}.
- R8: Size code 2 (word): `io_wdata` holds the four bytes of `cpu_wdata` in reverse order.
- R9: `io_rvalid`=1 gives `cpu_rvalid`=1 one cycle later. `cpu_rdata` is `io_rdata` lane-reversed by the R6 to R8 rules, using the size of the most recent forwarded read (byte before any read has been forwarded).
- R10: A request with size code 3 is never forwarded (`io_req` stays 0).
- R11: `io_size` equals the size code of the forwarded request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sel | input | 1 | Address mode: 0 = flat, 1 = paged |
| cpu_req | input | 1 | Processor request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Size code: 0 = byte, 1 = halfword, 2 = word, 3 = reserved |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Big-endian write data |
| io_rvalid | input | 1 | Read data strobe from the port bus |
| io_rdata | input | 32 | Little-endian read data |
| io_req | output | 1 | Port bus request strobe |
| io_we | output | 1 | Port bus write flag |
| io_size | output | 2 | Port bus size code |
| io_addr | output | 16 | Port number |
| io_wdata | output | 32 | Lane-reversed write data |
| cpu_rvalid | output | 1 | Read data strobe to the processor |
| cpu_rdata | output | 32 | Lane-reversed read data |

## Verification
Addresses are chosen at both edges of the aperture and just outside it. This separates a correct window compare from one that is off by a bit.

Paged-mode addresses have distinct patterns in the page bits and in the low five bits. A wrong shift or a wrong mask then shows up in `io_addr`.

Write data and read-return data use a different value in every byte lane, for each size code. This makes a missing, partial or misdirected reversal visible.

Some reads are answered after a read of a different size has been issued. The mode input is also toggled on the cycle right after a request. These two patterns show whether the stored read size and the per-request mode sampling are used correctly.

// File: rtl/iox_pkg.sv
package iox_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    function automatic logic size_ok(input logic [1:0] sz);
        return sz != SZ_RSVD;
    endfunction

endpackage

// File: rtl/iox_addr_map.sv
module iox_addr_map #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
    parameter int          WIN_BITS  = 23,
    parameter int          PORT_W    = 16,
    parameter int          LOW_BITS  = 5,
    parameter int          PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              paged,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    localparam int TAG_W  = ADDR_W - WIN_BITS;
    localparam int PAGE_W = PORT_W - LOW_BITS;

    logic [TAG_W-1:0]    tag;
    logic [WIN_BITS-1:0] offset;
    logic [PORT_W-1:0]   flat_port;
    logic [PORT_W-1:0]   paged_port;

    assign tag    = addr[ADDR_W-1:WIN_BITS];
    assign offset = addr[WIN_BITS-1:0];
    assign hit    = (tag == WIN_BASE[ADDR_W-1:WIN_BITS]);

    // Flat mode keeps the low port-width bits of the aperture offset.
    assign flat_port = offset[PORT_W-1:0];

    // Paged mode: page number lands just above the low offset bits.
    generate
        if (PAGE_BITS + PAGE_W <= WIN_BITS) begin : g_page_fits
            assign paged_port = {offset[PAGE_BITS +: PAGE_W], offset[LOW_BITS-1:0]};
        end else begin : g_page_pad
            localparam int AVAIL = WIN_BITS - PAGE_BITS;
            assign paged_port = {{(PAGE_W-AVAIL){1'b0}},
                                 offset[WIN_BITS-1:PAGE_BITS],
                                 offset[LOW_BITS-1:0]};
        end
    endgenerate

    assign port = paged ? paged_port : flat_port;

endmodule

// File: rtl/iox_lane_swap.sv
module iox_lane_swap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);
    import iox_pkg::*;

    localparam int NB = DATA_W / 8;

    generate
        for (genvar i = 0; i < NB; i++) begin : g_lane
            always_comb begin
                dout[i*8 +: 8] = 8'h00;
                unique case (xfer_size_e'(size))
                    SZ_BYTE: if (i == 0) dout[i*8 +: 8] = din[7:0];
                    SZ_HALF: if (i < 2)  dout[i*8 +: 8] = din[(1-i)*8 +: 8];
                    SZ_WORD: if (i < 4)  dout[i*8 +: 8] = din[(3-i)*8 +: 8];
                    default: dout[i*8 +: 8] = 8'h00;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/iox_bridge.sv
module iox_bridge #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
    parameter int          WIN_BITS  = 23,
    parameter int          PORT_W    = 16,
    parameter int          LOW_BITS  = 5,
    parameter int          PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sel,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              io_rvalid,
    input  logic [DATA_W-1:0] io_rdata,
    output logic              io_req,
    output logic              io_we,
    output logic [1:0]        io_size,
    output logic [PORT_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata
);
    import iox_pkg::*;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [1:0]        size;
        logic [PORT_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        rd_size;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic              win_hit;
    logic [PORT_W-1:0] port_num;
    logic [DATA_W-1:0] wdata_sw;
    logic [DATA_W-1:0] rdata_sw;
    logic              fwd;

    iox_addr_map #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS),
        .PORT_W(PORT_W), .LOW_BITS(LOW_BITS), .PAGE_BITS(PAGE_BITS)
    ) u_map (
        .addr (cpu_addr),
        .paged(map_sel),
        .hit  (win_hit),
        .port (port_num)
    );

    iox_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .din (cpu_wdata),
        .size(cpu_size),
        .dout(wdata_sw)
    );

    // Return data is sized by the last read that went out.
    iox_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .din (io_rdata),
        .size(st_q.rd_size),
        .dout(rdata_sw)
    );

    assign fwd = cpu_req && win_hit && size_ok(cpu_size);

    always_comb begin
        st_d        = st_q;
        st_d.req    = fwd;
        st_d.rvalid = io_rvalid;
        if (fwd) begin
            st_d.we    = cpu_we;
            st_d.size  = cpu_size;
            st_d.addr  = port_num;
            st_d.wdata = cpu_we ? wdata_sw : '0;
            if (!cpu_we) begin
                st_d.rd_size = cpu_size;
            end
        end
        if (io_rvalid) begin
            st_d.rdata = rdata_sw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rd_size <= SZ_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_req     = st_q.req;
    assign io_we      = st_q.we;
    assign io_size    = st_q.size;
    assign io_addr    = st_q.addr;
    assign io_wdata   = st_q.wdata;
    assign cpu_rvalid = st_q.rvalid;
    assign cpu_rdata  = st_q.rdata;

    // R2: a port strobe always traces back to an in-window processor strobe
    p_req_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> ($past(cpu_req) && $past(cpu_addr[ADDR_W-1:WIN_BITS]) == WIN_BASE[ADDR_W-1:WIN_BITS]));

    // R3: flat mode keeps the low offset bits
    p_flat_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !$past(map_sel)) |-> io_addr == $past(cpu_addr[PORT_W-1:0]));

    // R4: paged mode keeps the low five bits in place
    p_paged_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && $past(map_sel)) |-> io_addr[LOW_BITS-1:0] == $past(cpu_addr[LOW_BITS-1:0]));

    // R6: a byte write clears every lane but the lowest
    p_byte_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_we && io_size == SZ_BYTE) |-> io_wdata[DATA_W-1:8] == '0);

    // R9: return strobe is delayed by one cycle
    p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid == $past(io_rvalid));

    // R10: reserved size never reaches the port bus
    p_rsvd_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> io_size != SZ_RSVD);

endmodule

// File: tb/iox_bridge_test.sv
module iox_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sel = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        io_rvalid = 1'b0;
    logic [31:0] io_rdata = '0;
    logic        io_req, io_we, cpu_rvalid;
    logic [1:0]  io_size;
    logic [15:0] io_addr;
    logic [31:0] io_wdata, cpu_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    iox_bridge uut (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .io_req(io_req), .io_we(io_we), .io_size(io_size), .io_addr(io_addr),
        .io_wdata(io_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
    );

    // Behavioural reference
    function automatic logic [31:0] rev(input logic [31:0] d, input int sz);
        logic [31:0] r = '0;
        int n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        for (int i = 0; i < n; i++) r[i*8 +: 8] = d[(n-1-i)*8 +: 8];
        return r;
    endfunction

    logic        e_req = 0, e_we = 0, e_rv = 0, e_mode = 0;
    int          e_size = 0, e_rdsz = 0;
    logic [15:0] e_addr = 0;
    logic [31:0] e_wdata = 0, e_rdata = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_req  <= 0;
            e_rv   <= 0;
            e_rdsz <= 0;
        end else begin
            logic hit;
            hit = cpu_req && (cpu_addr >= 32'h8000_0000) && (cpu_addr <= 32'h807F_FFFF) && (cpu_size != 3);
            e_req <= hit;
            if (hit) begin
                e_we   <= cpu_we;
                e_size <= cpu_size;
                e_mode <= map_sel;
                e_addr <= map_sel ? 16'(((cpu_addr & 32'h1F) | ((cpu_addr & 32'h7FF000) >> 7)))
                                  : 16'(cpu_addr % 65536);
                e_wdata <= cpu_we ? rev(cpu_wdata, cpu_size) : 32'h0;
                if (!cpu_we) e_rdsz <= cpu_size;
            end
            e_rv <= io_rvalid;
            if (io_rvalid) e_rdata <= rev(io_rdata, e_rdsz);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 io_req", 32'(io_req), 32'(e_req));
            chk("R9 cpu_rvalid", 32'(cpu_rvalid), 32'(e_rv));
            if (e_req) begin
                chk("R2 io_we", 32'(io_we), 32'(e_we));
                chk("R11 io_size", 32'(io_size), 32'(e_size));
                chk(e_mode ? "R4 io_addr paged" : "R3 io_addr flat", 32'(io_addr), 32'(e_addr));
                if (e_we)
                    chk(e_size == 0 ? "R6 byte wdata" : e_size == 1 ? "R7 half wdata" : "R8 word wdata",
                        io_wdata, e_wdata);
            end
            if (e_rv) chk("R9 cpu_rdata", cpu_rdata, e_rdata);
        end
    end

    task automatic acc(input logic [31:0] a, input logic we, input logic [1:0] sz,
                       input logic [31:0] d, input logic m);
        @(negedge clk);
        cpu_req = 1; cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = d; map_sel = m;
    endtask

    task automatic idle();
        @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic ret(input logic [31:0] d);
        @(negedge clk);
        cpu_req = 0; io_rvalid = 1; io_rdata = d;
        @(negedge clk);
        io_rvalid = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 io_req in reset", 32'(io_req), 0);
        chk("R1 cpu_rvalid in reset", 32'(cpu_rvalid), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 io_req after reset", 32'(io_req), 0);

        // R3 flat mode, R6 R7 R8 writes, window edges
        acc(32'h8000_0000, 1, 0, 32'hA1B2C3D4, 0);
        acc(32'h8000_03F8, 1, 1, 32'h11223344, 0);
        acc(32'h807F_FFFF, 1, 2, 32'h5566_7788, 0);
        idle();
        @(negedge clk);
        chk("R8 directed word swap", io_wdata, 32'h8877_6655);
        chk("R3 directed flat addr", 32'(io_addr), 32'hFFFF);

        // R2 outside aperture
        acc(32'h7FFF_FFFF, 1, 0, 32'hFF, 0);
        acc(32'h8080_0000, 1, 0, 32'hFF, 1);
        acc(32'h0000_0092, 0, 0, 32'h0, 0);
        idle();
        @(negedge clk);
        chk("R2 outside no strobe", 32'(io_req), 0);

        // R4 paged mode
        acc(32'h8000_3004, 1, 1, 32'hBEEF_CAFE, 1);
        idle();
        chk("R4 directed paged addr", 32'(io_addr), 32'h0064);
        chk("R7 directed half swap", io_wdata, 32'h0000_FECA);
        acc(32'h807F_F01F, 1, 2, 32'h0102_0304, 1);
        acc(32'h8055_A7E9, 1, 0, 32'h0000_009C, 1);

        // R5 mode changes right after a request
        acc(32'h8012_3456, 1, 0, 32'h5A, 1);
        @(negedge clk);
        map_sel = 0; cpu_req = 0;
        acc(32'h8012_3456, 1, 0, 32'h5A, 0);
        map_sel = 0;
        @(negedge clk);
        cpu_req = 0; map_sel = 1;
        chk("R5 flat after toggle", 32'(io_addr), 32'h3456);
        idle();

        // R10 reserved size
        acc(32'h8000_0010, 1, 3, 32'h1234_5678, 0);
        idle();
        chk("R10 reserved size blocked", 32'(io_req), 0);

        // R9 read returns with different sizes
        ret(32'hDEAD_BEEF);
        acc(32'h8000_0060, 0, 2, 32'h0, 0);
        idle();
        ret(32'h0A0B_0C0D);
        chk("R9 directed word read", cpu_rdata, 32'h0D0C_0B0A);
        acc(32'h8000_0064, 0, 1, 32'h0, 1);
        ret(32'h1234_ABCD);
        acc(32'h8000_0061, 0, 0, 32'h0, 0);
        ret(32'h7766_5544);
        acc(32'h8000_0062, 1, 2, 32'hCAFE_F00D, 0);
        ret(32'h99AA_BBCC);

        // back-to-back mixed traffic
        for (int k = 0; k < 40; k++) begin
            acc(32'h8000_0000 + (k * 32'h0001_3579), k[0], 2'(k % 4), 32'h0102_0304 * (k + 1), k[1]);
            io_rvalid = k[2];
            io_rdata  = 32'hF0E1_D2C3 ^ (k * 32'h1111_1111);
        end
        idle();
        io_rvalid = 0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule